// File: doc/BRIEF.md
# Dual-Pass Branch Prediction Sequencer

This block is the control core of a decoupled branch prediction front end. It asks the predictor for a new prediction and takes back the finalised result, together with the number of override bubbles that result must wait out. Once that wait is over it pushes one fetch-stream entry into a bounded stream queue. The predictor tables and the queue storage live outside the block. The block sees the queue only as a count of free slots, and it drives per-cycle counts of requests, finalisations and enqueues.

The request / finalise / enqueue sequence can be evaluated twice within one clock when the dual-pass mode input is high. The second evaluation starts from the state, bubble count and remaining free slots that the first evaluation left, so up to two stream entries leave per clock.

The block also counts consecutive resolve dequeue failures. After a run of them of threshold length it arms a one-shot flag. The next evaluation that would issue a request consumes the flag and skips that request, which leaves the predictor's port free for a resolve update.

Top module: `bpred_seq`

## Requirements
- R1: Synchronous active-high reset returns the sequencer to idle, clears the bubble count, the skip flag and the failure run, and drives every output count to zero.
- R2: An evaluation that starts idle with at least one free slot and no pending skip issues one request. It finalises in the same evaluation, and pass p loads its bubble count from bits [p*BUB_W +: BUB_W] of `fin_bubbles`.
- R3: With zero free slots, an idle evaluation issues no request and no enqueue.
- R4: An enqueue happens only when the sequencer is outstanding, the bubble count is zero and a free slot remains. It consumes that slot and returns the sequencer to idle. While the registered bubble count is non-zero, no enqueue happens in that cycle.
- R5: With `two_pred_en` high, two evaluations run per clock. The second sees the state and free slots left by the first, so a cycle enqueues at most min(2, `q_free`) entries.
- R6: With `two_pred_en` low, exactly one evaluation runs per clock: at most one request and one enqueue.
- R7: The bubble count drops by one at the end of every cycle, after the evaluations, and saturates at zero. A count of N loaded in cycle t lets the enqueue happen in cycle t+N.
- R8: FAIL_THRESH consecutive cycles with `deq_fail` high and `deq_ok` low arm the skip flag and restart the run. A cycle with `deq_ok` high restarts the run without arming the flag.
- R9: A pending skip is consumed by the first evaluation that is idle with a free slot. That evaluation issues no request, pulses `blk_o` and stays idle. In dual-pass mode the second evaluation of the same cycle may still request.
- R10: While the queue has no free slot, a pending skip stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| two_pred_en | input | 1 | Run two evaluations per clock |
| q_free | input | FREE_W | Free slots in the stream queue this cycle |
| fin_bubbles | input | PASSES*BUB_W | Override bubble count returned for a finalisation in each pass |
| deq_fail | input | 1 | A resolve dequeue failed this cycle |
| deq_ok | input | 1 | A resolve dequeue succeeded this cycle |
| req_cnt_o | output | CNT_W | Predictions requested in the previous cycle |
| fin_cnt_o | output | CNT_W | Predictions finalised in the previous cycle |
| enq_cnt_o | output | CNT_W | Stream entries enqueued in the previous cycle |
| blk_o | output | 1 | A request was skipped for resolve priority in the previous cycle |
| outstanding_o | output | 1 | A finalised prediction is waiting to be enqueued |
| bubbles_o | output | BUB_W | Remaining override bubbles |

## Verification
The hardest case to reach is a skip that is consumed in the first pass while the second pass of the same cycle requests, finalises and enqueues. A variant of it is the skip armed while the queue is full, which must survive until a slot frees. The stimulus first holds `q_free` at zero during a full run of dequeue failures. It then opens the queue with dual-pass mode on and zero bubbles. A reference model then follows long random stretches that mix free-slot counts of zero to three, bubble counts of zero to three and bursts of failures broken by successes. The bench compares all outputs on every clock.

// File: rtl/bpseq_pkg.sv
package bpseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_DONE = 2'd1,
    SQ_OUT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bpseq_pass.sv
// One evaluation of the request / finalise / enqueue sequence.
module bpseq_pass
  import bpseq_pkg::*;
#(
  parameter int BUB_W  = 3,
  parameter int FREE_W = 7
) (
  input  logic              active,
  input  seq_state_e        st_i,
  input  logic [BUB_W-1:0]  bub_i,
  input  logic [FREE_W-1:0] free_i,
  input  logic              pend_i,
  input  logic [BUB_W-1:0]  fin_bub_i,
  output seq_state_e        st_o,
  output logic [BUB_W-1:0]  bub_o,
  output logic [FREE_W-1:0] free_o,
  output logic              pend_o,
  output logic              req_o,
  output logic              fin_o,
  output logic              enq_o,
  output logic              blk_o
);

  seq_state_e st_a, st_b;
  logic [BUB_W-1:0] bub_b;

  // step 1: request or skip
  always_comb begin
    st_a   = st_i;
    pend_o = pend_i;
    req_o  = 1'b0;
    blk_o  = 1'b0;
    if (active && st_i == SQ_IDLE && free_i != '0) begin
      if (pend_i) begin
        pend_o = 1'b0;
        blk_o  = 1'b1;
      end else begin
        req_o = 1'b1;
        st_a  = SQ_DONE;
      end
    end
  end

  // step 2: finalise and load bubbles
  always_comb begin
    st_b  = st_a;
    bub_b = bub_i;
    fin_o = 1'b0;
    if (active && st_a == SQ_DONE) begin
      bub_b = fin_bub_i;
      fin_o = 1'b1;
      st_b  = SQ_OUT;
    end
  end

  // step 3: enqueue
  always_comb begin
    st_o   = st_b;
    bub_o  = bub_b;
    free_o = free_i;
    enq_o  = 1'b0;
    if (active && st_b == SQ_OUT && bub_b == '0 && free_i != '0) begin
      enq_o  = 1'b1;
      free_o = free_i - 1'b1;
      st_o   = SQ_IDLE;
    end
  end

endmodule

// File: rtl/bpseq_bubble_sat.sv
// End-of-cycle bubble countdown, saturating at zero.
module bpseq_bubble_sat #(
  parameter int BUB_W = 3
) (
  input  logic [BUB_W-1:0] bub_i,
  output logic [BUB_W-1:0] bub_o
);

  always_comb begin
    if (bub_i == '0) bub_o = '0;
    else             bub_o = bub_i - 1'b1;
  end

endmodule

// File: rtl/bpseq_fail_run.sv
// Counts consecutive resolve dequeue failures; pulses when the run reaches THRESH.
module bpseq_fail_run #(
  parameter int THRESH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic deq_fail,
  input  logic deq_ok,
  output logic raise
);

  localparam int CW = (THRESH > 1) ? $clog2(THRESH) : 1;

  logic [CW-1:0] run_q;
  logic          at_limit;

  assign at_limit = (run_q == CW'(THRESH - 1));
  assign raise    = !deq_ok && deq_fail && at_limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (deq_ok) begin
      run_q <= '0;
    end else if (deq_fail) begin
      if (at_limit) run_q <= '0;
      else          run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/bpred_seq.sv
module bpred_seq
  import bpseq_pkg::*;
#(
  parameter int PASSES      = 2,
  parameter int BUB_W       = 3,
  parameter int FREE_W      = 7,
  parameter int FAIL_THRESH = 8,
  localparam int CNT_W      = $clog2(PASSES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      two_pred_en,
  input  logic [FREE_W-1:0]         q_free,
  input  logic [PASSES*BUB_W-1:0]   fin_bubbles,
  input  logic                      deq_fail,
  input  logic                      deq_ok,
  output logic [CNT_W-1:0]          req_cnt_o,
  output logic [CNT_W-1:0]          fin_cnt_o,
  output logic [CNT_W-1:0]          enq_cnt_o,
  output logic                      blk_o,
  output logic                      outstanding_o,
  output logic [BUB_W-1:0]          bubbles_o
);

  seq_state_e        st_q;
  logic [BUB_W-1:0]  bub_q;
  logic              pend_q;

  seq_state_e        st_c   [PASSES+1];
  logic [BUB_W-1:0]  bub_c  [PASSES+1];
  logic [FREE_W-1:0] free_c [PASSES+1];
  logic              pend_c [PASSES+1];

  logic [PASSES-1:0] req_v, fin_v, enq_v, blk_v;
  logic [CNT_W-1:0]  req_sum, fin_sum, enq_sum;
  logic [BUB_W-1:0]  bub_next;
  logic              raise;

  assign st_c[0]   = st_q;
  assign bub_c[0]  = bub_q;
  assign free_c[0] = q_free;
  assign pend_c[0] = pend_q;

  for (genvar p = 0; p < PASSES; p++) begin : g_pass
    bpseq_pass #(
      .BUB_W (BUB_W),
      .FREE_W(FREE_W)
    ) u_pass (
      .active   ((p == 0) || two_pred_en),
      .st_i     (st_c[p]),
      .bub_i    (bub_c[p]),
      .free_i   (free_c[p]),
      .pend_i   (pend_c[p]),
      .fin_bub_i(fin_bubbles[p*BUB_W +: BUB_W]),
      .st_o     (st_c[p+1]),
      .bub_o    (bub_c[p+1]),
      .free_o   (free_c[p+1]),
      .pend_o   (pend_c[p+1]),
      .req_o    (req_v[p]),
      .fin_o    (fin_v[p]),
      .enq_o    (enq_v[p]),
      .blk_o    (blk_v[p])
    );
  end

  always_comb begin
    req_sum = '0;
    fin_sum = '0;
    enq_sum = '0;
    for (int p = 0; p < PASSES; p++) begin
      req_sum = req_sum + CNT_W'(req_v[p]);
      fin_sum = fin_sum + CNT_W'(fin_v[p]);
      enq_sum = enq_sum + CNT_W'(enq_v[p]);
    end
  end

  bpseq_bubble_sat #(.BUB_W(BUB_W)) u_bub (
    .bub_i(bub_c[PASSES]),
    .bub_o(bub_next)
  );

  bpseq_fail_run #(.THRESH(FAIL_THRESH)) u_fail (
    .clk     (clk),
    .rst     (rst),
    .deq_fail(deq_fail),
    .deq_ok  (deq_ok),
    .raise   (raise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      bub_q     <= '0;
      pend_q    <= 1'b0;
      req_cnt_o <= '0;
      fin_cnt_o <= '0;
      enq_cnt_o <= '0;
      blk_o     <= 1'b0;
    end else begin
      st_q      <= st_c[PASSES];
      bub_q     <= bub_next;
      pend_q    <= pend_c[PASSES] | raise;
      req_cnt_o <= req_sum;
      fin_cnt_o <= fin_sum;
      enq_cnt_o <= enq_sum;
      blk_o     <= |blk_v;
    end
  end

  assign outstanding_o = (st_q == SQ_OUT);
  assign bubbles_o     = bub_q;

endmodule

// File: rtl/bpred_seq_chk.sv
module bpred_seq_chk #(
  parameter int PASSES = 2,
  parameter int BUB_W  = 3,
  parameter int FREE_W = 7,
  localparam int CNT_W = $clog2(PASSES + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              two_pred_en,
  input logic [FREE_W-1:0] q_free,
  input logic [CNT_W-1:0]  req_cnt_o,
  input logic [CNT_W-1:0]  fin_cnt_o,
  input logic [CNT_W-1:0]  enq_cnt_o,
  input logic              blk_o,
  input logic              outstanding_o,
  input logic [BUB_W-1:0]  bubbles_o
);

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  assert_no_work_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(q_free) == '0) |-> (req_cnt_o == '0 && enq_cnt_o == '0));

  assert_enq_within_slots_R5: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (enq_cnt_o <= $past(q_free)));

  assert_single_pass_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(two_pred_en)) |-> (req_cnt_o <= 1 && enq_cnt_o <= 1));

  assert_bubble_countdown_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && fin_cnt_o == '0 && $past(bubbles_o) != '0)
      |-> (bubbles_o == $past(bubbles_o) - 1'b1));

  assert_no_enq_under_bubble_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(outstanding_o) && $past(bubbles_o) != '0) |-> (enq_cnt_o == '0));

  assert_skip_costs_request_R9: assert property (@(posedge clk) disable iff (rst)
    blk_o |-> (req_cnt_o <= PASSES - 1));

endmodule

bind bpred_seq bpred_seq_chk #(
  .PASSES(PASSES),
  .BUB_W (BUB_W),
  .FREE_W(FREE_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .two_pred_en  (two_pred_en),
  .q_free       (q_free),
  .req_cnt_o    (req_cnt_o),
  .fin_cnt_o    (fin_cnt_o),
  .enq_cnt_o    (enq_cnt_o),
  .blk_o        (blk_o),
  .outstanding_o(outstanding_o),
  .bubbles_o    (bubbles_o)
);

// File: tb/bpred_seq_bench.sv
module bpred_seq_bench;

  localparam int PASSES = 2;
  localparam int BUB_W  = 3;
  localparam int FREE_W = 7;
  localparam int THR    = 8;
  localparam int CNT_W  = $clog2(PASSES + 1);

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    two_pred_en = 1'b0;
  logic [FREE_W-1:0]       q_free = '0;
  logic [PASSES*BUB_W-1:0] fin_bubbles = '0;
  logic                    deq_fail = 1'b0;
  logic                    deq_ok = 1'b0;
  logic [CNT_W-1:0]        req_cnt_o, fin_cnt_o, enq_cnt_o;
  logic                    blk_o, outstanding_o;
  logic [BUB_W-1:0]        bubbles_o;

  always #4 clk = ~clk;

  bpred_seq #(.PASSES(PASSES), .BUB_W(BUB_W), .FREE_W(FREE_W), .FAIL_THRESH(THR)) u_bpred_seq (
    .clk(clk), .rst(rst), .two_pred_en(two_pred_en), .q_free(q_free),
    .fin_bubbles(fin_bubbles), .deq_fail(deq_fail), .deq_ok(deq_ok),
    .req_cnt_o(req_cnt_o), .fin_cnt_o(fin_cnt_o), .enq_cnt_o(enq_cnt_o),
    .blk_o(blk_o), .outstanding_o(outstanding_o), .bubbles_o(bubbles_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model: waiting = a finalised prediction not yet enqueued
  bit m_wait, m_pend;
  int m_bub, m_run;
  int e_req, e_fin, e_enq, e_blk;

  task automatic model_tick();
    int left, n, b;
    bit asked;
    if (rst) begin
      m_wait = 0; m_pend = 0; m_bub = 0; m_run = 0;
      e_req = 0; e_fin = 0; e_enq = 0; e_blk = 0;
      return;
    end
    left = q_free;
    n = two_pred_en ? 2 : 1;
    e_req = 0; e_fin = 0; e_enq = 0; e_blk = 0;
    for (int p = 0; p < n; p++) begin
      asked = 0;
      if (!m_wait && left > 0) begin
        if (m_pend) begin m_pend = 0; e_blk = 1; end
        else asked = 1;
      end
      if (asked) begin
        e_req++; e_fin++;
        b = int'(fin_bubbles[p*BUB_W +: BUB_W]);
        m_bub = b;
        m_wait = 1;
      end
      if (m_wait && m_bub == 0 && left > 0) begin
        e_enq++; left--; m_wait = 0;
      end
    end
    if (m_bub > 0) m_bub--;
    if (deq_ok) m_run = 0;
    else if (deq_fail) begin
      if (m_run == THR - 1) begin m_run = 0; m_pend = 1; end
      else m_run++;
    end
  endtask

  task automatic check(input string tag, input string fld, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", tag, fld, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "req_cnt", int'(req_cnt_o), e_req);
    check(tag, "fin_cnt", int'(fin_cnt_o), e_fin);
    check(tag, "enq_cnt", int'(enq_cnt_o), e_enq);
    check(tag, "blk", int'(blk_o), e_blk);
    check(tag, "outstanding", int'(outstanding_o), int'(m_wait));
    check(tag, "bubbles", int'(bubbles_o), m_bub);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_tick();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_bub(input int b0, input int b1);
    fin_bubbles = {BUB_W'(b1), BUB_W'(b0)};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    step("R1"); step("R1");
    rst = 1'b0;
    compare("R1");

    // single pass, open queue, no bubbles
    two_pred_en = 0; q_free = 4; set_bub(0, 0);
    repeat (3) step("R6");
    step("R2");

    // bubble countdown: 2 bubbles then enqueue
    set_bub(2, 1);
    repeat (5) step("R7");
    set_bub(3, 0);
    repeat (6) step("R4");

    // full queue blocks requests and enqueues
    q_free = 0;
    repeat (4) step("R3");
    q_free = 1;
    step("R3");

    // dual pass
    two_pred_en = 1; q_free = 4; set_bub(0, 0);
    repeat (4) step("R5");
    q_free = 1;
    repeat (3) step("R5");
    set_bub(0, 2); q_free = 3;
    repeat (4) step("R5");

    // failure run interrupted by a success: no skip
    set_bub(0, 0);
    deq_fail = 1;
    repeat (THR - 1) step("R8");
    deq_ok = 1; step("R8"); deq_ok = 0;
    repeat (THR - 1) step("R8");
    deq_fail = 0;
    repeat (2) step("R8");

    // skip armed while full, then consumed in first pass
    q_free = 0; deq_fail = 1;
    repeat (THR) step("R10");
    deq_fail = 0;
    repeat (4) step("R10");
    q_free = 3;
    repeat (3) step("R9");
    // skip in single pass mode
    two_pred_en = 0; deq_fail = 1;
    repeat (THR) step("R9");
    deq_fail = 0;
    repeat (3) step("R9");

    // mid-run reset
    set_bub(3, 3); step("R1");
    rst = 1; step("R1"); rst = 0; step("R1");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) two_pred_en = $urandom_range(0, 1);
      q_free = FREE_W'($urandom_range(0, 3));
      set_bub($urandom_range(0, 3) * $urandom_range(0, 1), $urandom_range(0, 3));
      deq_ok   = ($urandom_range(0, 15) == 0);
      deq_fail = ($urandom_range(0, 3) != 0);
      step("R2");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule